// File: doc/BRIEF.md
# Relocatable Memory Base Address Register

This block is a single 32-bit memory base address register as found in a PCI-style configuration header. Software learns how much address space the function needs by writing all ones and reading the register back: the address bits that stayed zero mark the size of the region. Software then writes the chosen base address, and the block decodes incoming memory addresses against it.

The region size is a power-of-two parameter of at least 16 bytes. The address bits below that size cannot be written, so the base is always aligned to the size. The four low bits of a read carry fixed type information: a memory-space region, 32-bit decoding, and a prefetchable flag chosen by parameter. Writes honour per-byte-lane enables. A read strobe captures the register image into a read-data register on the next clock. The programmed base and a combinational hit flag for memory accesses are always visible at the ports.

Top module: `pci_mem_bar`

## Requirements
- R1: Bit 0 of every read value is 0, which marks a memory-space region.
- R2: Bits 2:1 of every read value are 00, which marks a region decodable anywhere in 32-bit space.
- R3: Bit 3 of every read value equals the PREFETCH parameter, and no write changes it.
- R4: Every address bit below log2(REGION_BYTES) reads 0 and is 0 on `base_o`, whatever was written.
- R5: After all ones are written to all four lanes, a read value v gives (~(v & 32'hFFFF_FFF0)) + 1 == REGION_BYTES.
- R6: A write stores the written data ANDed with ~(REGION_BYTES-1) into the enabled lanes, replacing any earlier value, including the probe pattern.
- R7: After reset `base_o` is 0 and a read returns only the prefetch bit (32'h8 when PREFETCH=1, else 0).
- R8: `cfg_be_i[k]` enables byte lane k (bits 8k+7:8k); lanes whose enable is 0 keep their previous value.
- R9: With `mem_en_i` high, `hit_o` is 1 exactly when `mem_addr_i` and `base_o` agree in every bit at or above log2(REGION_BYTES).
- R10: With `mem_en_i` low, `hit_o` is 0 for every address.
- R11: `cfg_rdata_o` takes the register image on the clock edge where `cfg_rd_i` is high and holds it otherwise; a write is visible on `base_o` after the clock edge where `cfg_wr_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_rd_i | input | 1 | Configuration read strobe |
| cfg_be_i | input | 4 | Byte lane enables for writes |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Register image captured on the last read strobe |
| mem_en_i | input | 1 | Memory-space decode enable |
| mem_addr_i | input | 32 | Memory access address to decode |
| base_o | output | 32 | Programmed, size-aligned base address |
| hit_o | output | 1 | Memory address falls inside the region |

## Verification
The embedded assertions watch, on every cycle, that the type bits of a captured read are fixed, that disabled lanes and idle cycles leave the base untouched, that a full-lane write lands masked on the base, that read data holds between strobes, and that a hit never appears with decoding disabled. Only the bench scenarios show the size-probe arithmetic giving back the configured region size, the reset image, the per-lane merge across all sixteen enable patterns, and the hit boundaries just inside and just outside the region. It runs the same stimulus on a large non-prefetchable region and on the smallest legal prefetchable region.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;
  localparam int unsigned BAR_W    = 32;
  localparam int unsigned LANES    = BAR_W / 8;
  localparam int unsigned INFO_W   = 4;
  localparam int unsigned MIN_SIZE = 16;

  typedef logic [BAR_W-1:0] bar_word_t;

  function automatic bar_word_t addr_mask(input int unsigned size_log2);
    return ~((bar_word_t'(1) << size_log2) - bar_word_t'(1));
  endfunction

  function automatic bar_word_t info_bits(input bit prefetch);
    bar_word_t w;
    w = '0;
    w[3] = prefetch;
    return w;
  endfunction
endpackage

// File: rtl/pci_bar_store.sv
module pci_bar_store
  import pci_bar_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [LANES-1:0] be_i,
  input  bar_word_t        wdata_i,
  output bar_word_t        base_o
);
  localparam bar_word_t WMASK = addr_mask(SIZE_LOG2);

  bar_word_t base_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[l*8 +: 8] <= '0;
      end else if (wr_i && be_i[l]) begin
        base_q[l*8 +: 8] <= wdata_i[l*8 +: 8] & WMASK[l*8 +: 8];
      end
    end

    // R8
    lane_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && be_i[l]) |=> base_q[l*8 +: 8] == $past(base_q[l*8 +: 8]));
  end

  assign base_o = base_q;

  // R6
  full_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && &be_i) |=> base_q == ($past(wdata_i) & WMASK));

  // R11
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(base_q));
endmodule

// File: rtl/pci_bar_readback.sv
module pci_bar_readback
  import pci_bar_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12,
  parameter bit          PREFETCH  = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rd_i,
  input  bar_word_t base_i,
  output bar_word_t rdata_o
);
  localparam bar_word_t WMASK = addr_mask(SIZE_LOG2);
  localparam bar_word_t INFO  = info_bits(PREFETCH);

  bar_word_t rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= INFO;
    end else if (rd_i) begin
      rdata_q <= (base_i & WMASK) | INFO;
    end
  end

  assign rdata_o = rdata_q;

  // R1
  mem_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rdata_q[0] == 1'b0);

  // R2
  decode32_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rdata_q[2:1] == 2'b00);

  // R3
  prefetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rdata_q[3] == PREFETCH);

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/pci_bar_decode.sv
module pci_bar_decode
  import pci_bar_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 12
) (
  input  logic      mem_en_i,
  input  bar_word_t mem_addr_i,
  input  bar_word_t base_i,
  output logic      hit_o
);
  localparam bar_word_t WMASK = addr_mask(SIZE_LOG2);

  // only bits at or above the region size take part in the compare
  always_comb begin
    hit_o = mem_en_i && (((mem_addr_i ^ base_i) & WMASK) == '0);
  end
endmodule

// File: rtl/pci_mem_bar.sv
module pci_mem_bar
  import pci_bar_pkg::*;
#(
  parameter int unsigned REGION_BYTES = 4096,
  parameter bit          PREFETCH     = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_wr_i,
  input  logic        cfg_rd_i,
  input  logic [3:0]  cfg_be_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        mem_en_i,
  input  logic [31:0] mem_addr_i,
  output logic [31:0] base_o,
  output logic        hit_o
);
  localparam int unsigned SIZE_LOG2 = $clog2(REGION_BYTES);
  localparam bar_word_t   LOW_MASK  = ~addr_mask(SIZE_LOG2);

  bar_word_t base_w;
  logic      hit_w;

  pci_bar_store #(.SIZE_LOG2(SIZE_LOG2)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .be_i    (cfg_be_i),
    .wdata_i (cfg_wdata_i),
    .base_o  (base_w)
  );

  pci_bar_readback #(.SIZE_LOG2(SIZE_LOG2), .PREFETCH(PREFETCH)) u_readback (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (cfg_rd_i),
    .base_i  (base_w),
    .rdata_o (cfg_rdata_o)
  );

  pci_bar_decode #(.SIZE_LOG2(SIZE_LOG2)) u_decode (
    .mem_en_i   (mem_en_i),
    .mem_addr_i (mem_addr_i),
    .base_i     (base_w),
    .hit_o      (hit_w)
  );

  assign base_o = base_w;
  assign hit_o  = hit_w;

  // R10
  hit_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> mem_en_i);

  // R4
  aligned_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rd_i |=> (cfg_rdata_o & LOW_MASK & ~bar_word_t'(32'hF)) == '0);

  // R9
  own_base_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_i && mem_addr_i == base_o) |-> hit_o);
endmodule

// File: tb/pci_mem_bar_bench.sv
module pci_mem_bar_bench;
  localparam int unsigned SIZE_A = 4096;
  localparam int unsigned SIZE_B = 16;
  localparam logic [31:0] MASK_A = ~(SIZE_A - 1);
  localparam logic [31:0] MASK_B = ~(SIZE_B - 1);

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        cfg_rd_i = 1'b0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        mem_en_i = 1'b0;
  logic [31:0] mem_addr_i = '0;
  logic [31:0] rdata_a, rdata_b, base_a, base_b;
  logic        hit_a, hit_b;

  logic [31:0] exp_a = '0;
  logic [31:0] exp_b = '0;
  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  pci_mem_bar #(.REGION_BYTES(SIZE_A), .PREFETCH(1'b0)) u_pci_mem_bar (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_rd_i, .cfg_be_i, .cfg_wdata_i,
    .cfg_rdata_o(rdata_a), .mem_en_i, .mem_addr_i, .base_o(base_a), .hit_o(hit_a)
  );

  pci_mem_bar #(.REGION_BYTES(SIZE_B), .PREFETCH(1'b1)) u_pci_mem_bar_min (
    .clk_i, .rst_ni, .cfg_wr_i, .cfg_rd_i, .cfg_be_i, .cfg_wdata_i,
    .cfg_rdata_o(rdata_b), .mem_en_i, .mem_addr_i, .base_o(base_b), .hit_o(hit_b)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be, input logic [31:0] m);
    logic [31:0] r;
    r = old;
    for (int l = 0; l < 4; l++)
      if (be[l]) r[l*8 +: 8] = d[l*8 +: 8] & m[l*8 +: 8];
    return r;
  endfunction

  task automatic cfg_write(input logic [3:0] be, input logic [31:0] d);
    @(negedge clk_i);
    cfg_wr_i = 1'b1; cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_wr_i = 1'b0; cfg_be_i = '0;
    exp_a = merge(exp_a, d, be, MASK_A);
    exp_b = merge(exp_b, d, be, MASK_B);
  endtask

  task automatic cfg_read;
    @(negedge clk_i);
    cfg_rd_i = 1'b1;
    @(negedge clk_i);
    cfg_rd_i = 1'b0;
  endtask

  task automatic check_state(input string req);
    cmp({req, " base A"}, base_a, exp_a);
    cmp({req, " base B"}, base_b, exp_b);
    cfg_read();
    cmp({req, " read A"}, rdata_a, exp_a);
    cmp({req, " read B"}, rdata_b, exp_b | 32'h8);
    // R1 R2 R3 type bits
    cmp("R1 R2 R3 info A", {28'd0, rdata_a[3:0]}, 32'h0);
    cmp("R1 R2 R3 info B", {28'd0, rdata_b[3:0]}, 32'h8);
    // R4 bits below the size
    cmp("R4 low A", rdata_a & (SIZE_A - 1) & ~32'hF, 32'h0);
    cmp("R4 low B", base_b & (SIZE_B - 1), 32'h0);
  endtask

  task automatic check_hit(input logic [31:0] addr, input logic en);
    @(negedge clk_i);
    mem_addr_i = addr; mem_en_i = en;
    #1;
    cmp(en ? "R9 hit A" : "R10 hit A", {31'd0, hit_a},
        {31'd0, en && (((addr ^ exp_a) & MASK_A) == 0)});
    cmp(en ? "R9 hit B" : "R10 hit B", {31'd0, hit_b},
        {31'd0, en && (((addr ^ exp_b) & MASK_B) == 0)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 reset image
    cmp("R7 reset base A", base_a, 32'h0);
    cmp("R7 reset base B", base_b, 32'h0);
    cfg_read();
    cmp("R7 reset read A", rdata_a, 32'h0);
    cmp("R7 reset read B", rdata_b, 32'h8);

    // R5 size probe
    cfg_write(4'hF, 32'hFFFF_FFFF);
    check_state("R5 probe");
    cmp("R5 size A", ~(rdata_a & 32'hFFFF_FFF0) + 32'd1, SIZE_A);
    cmp("R5 size B", ~(rdata_b & 32'hFFFF_FFF0) + 32'd1, SIZE_B);

    // R6 address replaces the probe pattern
    cfg_write(4'hF, 32'h8765_4321);
    check_state("R6 program");

    // R8 every byte-enable pattern
    for (int i = 0; i < 16; i++) begin
      cfg_write(4'(i), 32'h9E37_79B9 * (i + 1));
      check_state("R8 lanes");
    end

    // R11 read data holds without a strobe
    cfg_read();
    held = rdata_a;
    cfg_write(4'hF, 32'hA5A5_5A5A);
    cmp("R11 hold A", rdata_a, held);
    check_state("R11 after read");

    // R9 R10 decode boundaries over several bases
    for (int b = 0; b < 4; b++) begin
      logic [31:0] base;
      base = 32'h1357_9BDF * (b + 3);
      cfg_write(4'hF, base);
      for (int e = 0; e < 2; e++) begin
        check_hit(exp_a, e[0]);
        check_hit(exp_a + SIZE_A - 1, e[0]);
        check_hit(exp_a + SIZE_A, e[0]);
        check_hit(exp_a - 1, e[0]);
        check_hit(exp_b + SIZE_B - 1, e[0]);
        check_hit(exp_b + SIZE_B, e[0]);
        check_hit(exp_b - 1, e[0]);
        check_hit(base ^ 32'h8000_0000, e[0]);
      end
    end
    mem_en_i = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule